// File: doc/BRIEF.md
# Branch Target Selection Controller

This block makes the fetch-time decision for one control-flow instruction. It receives the instruction's class flags, the fetch PC and the same-cycle answers of the surrounding predictor structures. These answers are the direction guess, the target-buffer lookup, the indirect-target lookup and the top of the return stack. From them the block chooses whether the instruction is predicted taken and which address fetch continues from. It also issues push and pop commands to the return stack and builds the record that the history queue stores. That record is later used to repair the return stack and to train the predictors. The predictor tables and the stack storage sit outside the block.

A taken decision can still be revoked. If the target buffer or the indirect predictor has no target for a branch the direction predictor called taken, fetch falls through to the sequential address. A conditional call that gets no target then does not leave a push behind. The record always carries the return-stack checkpoint of a return, whether or not that return was predicted taken.

The block can be built in two variants. One is an out-of-order-pipeline variant with an optional indirect predictor. The other is an in-order variant that guards returns against an empty stack and takes direct unconditional call targets from the instruction itself. All results are registered once, so they appear one cycle after the request.

Top module: `bts_ctrl`

## Requirements
- R1: An unconditional instruction is predicted taken whatever `dir_taken_i` says. A conditional one follows `dir_taken_i`, subject to the target checks below.
- R2: A return predicted taken drives `next_pc_o` to `ras_top_tgt_i`, raises `ras_pop_o` and sets the used-stack flag of the record.
- R3: For every return, taken or not, the record has `rec_was_return_o` set and holds `ras_top_idx_i` and `ras_top_tgt_i` as checkpoint. A return predicted not taken goes to PC+4, does not pop and never pushes. For non-returns the checkpoint fields are zero.
- R4: A call on the taken path raises `ras_push_o` with `ras_push_pc_o` equal to the call's PC. It sets both the was-call and the pushed-stack flags of the record.
- R5: A direct non-return branch on the taken path with a target-buffer hit is predicted taken to `btb_tgt_i`.
- R6: On a target-buffer miss on the taken path, the prediction becomes not taken and `next_pc_o` becomes PC+4. `dir_btb_upd_o` is raised for a non-call and stays low for a call.
- R7: A conditional call that misses on the taken path issues no net push and clears the pushed-stack flag, while was-call stays set. An unconditional call that misses keeps its push.
- R8: With the indirect predictor enabled, a non-direct non-return branch on the taken path sets `rec_was_indirect_o`. On `ind_hit_i` it is taken to `ind_tgt_i`. On a miss it becomes not taken to PC+4, with no target-buffer update, and `btb_hit_i` has no effect.
- R9: With the indirect predictor disabled, a non-direct branch uses the target buffer exactly as a direct one does.
- R10: In the in-order variant, an unconditional return with `ras_empty_i` high is predicted not taken to PC+4 and does not pop. In the other variant `ras_empty_i` has no effect.
- R11: In the in-order variant, an unconditional direct call is predicted taken to `imm_tgt_i` and pushes, even on a target-buffer miss.
- R12: Results appear one clock after `valid_i`, with `out_valid_o` high. In an idle cycle and after reset, `out_valid_o`, `ras_push_o`, `ras_pop_o` and `dir_btb_upd_o` are low.
- R13: `ras_push_o` and `ras_pop_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A control instruction is presented this cycle |
| is_uncond_i | input | 1 | Instruction is unconditional |
| is_call_i | input | 1 | Instruction is a call |
| is_ret_i | input | 1 | Instruction is a return |
| is_direct_i | input | 1 | Target is encoded in the instruction (low: register-indirect) |
| pc_i | input | PC_W | Fetch PC of the instruction |
| dir_taken_i | input | 1 | Direction predictor result |
| btb_hit_i | input | 1 | Target buffer hit |
| btb_tgt_i | input | PC_W | Target buffer target |
| ind_hit_i | input | 1 | Indirect predictor hit |
| ind_tgt_i | input | PC_W | Indirect predictor target |
| ras_top_tgt_i | input | PC_W | Return stack top entry |
| ras_top_idx_i | input | IDX_W | Return stack top index |
| ras_empty_i | input | 1 | Return stack is empty |
| imm_tgt_i | input | PC_W | Target computed from the instruction's immediate |
| out_valid_o | output | 1 | Registered result is valid |
| taken_o | output | 1 | Final predicted-taken bit |
| next_pc_o | output | PC_W | Address fetch continues from |
| ras_push_o | output | 1 | Push command for the return stack |
| ras_push_pc_o | output | PC_W | Value to push |
| ras_pop_o | output | 1 | Pop command for the return stack |
| dir_btb_upd_o | output | 1 | Tell the direction predictor a taken guess lost its target |
| rec_pc_o | output | PC_W | Record: instruction PC |
| rec_used_ras_o | output | 1 | Record: target came from the stack |
| rec_ras_idx_o | output | IDX_W | Record: checkpoint top index |
| rec_ras_tgt_o | output | PC_W | Record: checkpoint top target |
| rec_pushed_ras_o | output | 1 | Record: a push remains in effect |
| rec_was_call_o | output | 1 | Record: call on the taken path |
| rec_was_return_o | output | 1 | Record: instruction is a return |
| rec_was_indirect_o | output | 1 | Record: indirect predictor consulted |

## Verification
The bench builds three instances side by side from the same stimulus. The first uses the defaults: out-of-order variant, indirect predictor on, 32-bit PC and a 16-entry stack. This instance carries the vector table through every class and hit/miss combination. The second has the indirect predictor switched off, so indirect branches run through the target-buffer path. The third is the in-order variant, which makes the empty-stack return guard and the immediate call target reachable.

// File: rtl/bts_pkg.sv
package bts_pkg;

   // where the next fetch address comes from
   typedef enum logic [2:0] {
      TS_SEQ = 3'd0,
      TS_RAS = 3'd1,
      TS_BTB = 3'd2,
      TS_IND = 3'd3,
      TS_IMM = 3'd4
   } tgt_src_e;

   typedef struct packed {
      logic uncond;
      logic call;
      logic ret;
      logic direct;
   } ctl_class_t;

endpackage

// File: rtl/bts_dir_sel.sv
module bts_dir_sel
   import bts_pkg::*;
#(
   parameter bit IN_ORDER = 1'b0
) (
   input  ctl_class_t cls_i,
   input  logic       dir_taken_i,
   input  logic       ras_empty_i,
   output logic       dir_o
);

   generate
      if (IN_ORDER) begin : g_inorder
         // unconditional returns with nothing on the stack fall through
         always_comb begin
            if (cls_i.uncond) dir_o = !(cls_i.ret && ras_empty_i);
            else              dir_o = dir_taken_i;
         end
      end else begin : g_ooo
         logic unused_empty;
         assign unused_empty = ras_empty_i;
         always_comb dir_o = cls_i.uncond | dir_taken_i;
      end
   endgenerate

endmodule

// File: rtl/bts_tgt_sel.sv
module bts_tgt_sel
   import bts_pkg::*;
#(
   parameter bit USE_INDIRECT = 1'b1,
   parameter bit IN_ORDER     = 1'b0
) (
   input  ctl_class_t cls_i,
   input  logic       dir_i,
   input  logic       btb_hit_i,
   input  logic       ind_hit_i,
   output tgt_src_e   src_o,
   output logic       taken_o,
   output logic       miss_o,
   output logic       dir_upd_o,
   output logic       was_ind_o
);

   localparam bit IND_EN = USE_INDIRECT && !IN_ORDER;
   localparam bit IMM_EN = IN_ORDER;

   logic use_imm;
   logic via_ind;

   generate
      if (IMM_EN) begin : g_imm
         assign use_imm = cls_i.call && cls_i.uncond && cls_i.direct;
      end else begin : g_no_imm
         assign use_imm = 1'b0;
      end
      if (IND_EN) begin : g_ind
         assign via_ind = !cls_i.direct;
      end else begin : g_no_ind
         logic unused_ind;
         assign unused_ind = ind_hit_i;
         assign via_ind    = 1'b0;
      end
   endgenerate

   always_comb begin
      src_o     = TS_SEQ;
      taken_o   = 1'b0;
      miss_o    = 1'b0;
      dir_upd_o = 1'b0;
      was_ind_o = 1'b0;
      if (dir_i) begin
         if (cls_i.ret) begin
            src_o   = TS_RAS;
            taken_o = 1'b1;
         end else if (use_imm) begin
            src_o   = TS_IMM;
            taken_o = 1'b1;
         end else if (!via_ind) begin
            if (btb_hit_i) begin
               src_o   = TS_BTB;
               taken_o = 1'b1;
            end else begin
               miss_o    = 1'b1;
               dir_upd_o = !cls_i.call;
            end
         end else begin
            was_ind_o = 1'b1;
            if (ind_hit_i) begin
               src_o   = TS_IND;
               taken_o = 1'b1;
            end else begin
               miss_o = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bts_ras_ctl.sv
module bts_ras_ctl
   import bts_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int IDX_W = 4
) (
   input  ctl_class_t         cls_i,
   input  logic               dir_i,
   input  logic               miss_i,
   input  logic [IDX_W-1:0]   top_idx_i,
   input  logic [PC_W-1:0]    top_tgt_i,
   output logic               push_o,
   output logic               pop_o,
   output logic               was_call_o,
   output logic [IDX_W-1:0]   ck_idx_o,
   output logic [PC_W-1:0]    ck_tgt_o
);

   logic undo_push;

   always_comb begin
      was_call_o = dir_i && cls_i.call && !cls_i.ret;
      // a conditional call that found no target leaves no push behind
      undo_push  = miss_i && !cls_i.uncond;
      push_o     = was_call_o && !undo_push;
      pop_o      = dir_i && cls_i.ret;
      ck_idx_o   = cls_i.ret ? top_idx_i : '0;
      ck_tgt_o   = cls_i.ret ? top_tgt_i : '0;
   end

endmodule

// File: rtl/bts_ctrl.sv
module bts_ctrl
   import bts_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int RAS_DEPTH    = 16,
   parameter int INST_BYTES   = 4,
   parameter bit USE_INDIRECT = 1'b1,
   parameter bit IN_ORDER     = 1'b0,
   localparam int IDX_W       = $clog2(RAS_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic               is_uncond_i,
   input  logic               is_call_i,
   input  logic               is_ret_i,
   input  logic               is_direct_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic               dir_taken_i,
   input  logic               btb_hit_i,
   input  logic [PC_W-1:0]    btb_tgt_i,
   input  logic               ind_hit_i,
   input  logic [PC_W-1:0]    ind_tgt_i,
   input  logic [PC_W-1:0]    ras_top_tgt_i,
   input  logic [IDX_W-1:0]   ras_top_idx_i,
   input  logic               ras_empty_i,
   input  logic [PC_W-1:0]    imm_tgt_i,
   output logic               out_valid_o,
   output logic               taken_o,
   output logic [PC_W-1:0]    next_pc_o,
   output logic               ras_push_o,
   output logic [PC_W-1:0]    ras_push_pc_o,
   output logic               ras_pop_o,
   output logic               dir_btb_upd_o,
   output logic [PC_W-1:0]    rec_pc_o,
   output logic               rec_used_ras_o,
   output logic [IDX_W-1:0]   rec_ras_idx_o,
   output logic [PC_W-1:0]    rec_ras_tgt_o,
   output logic               rec_pushed_ras_o,
   output logic               rec_was_call_o,
   output logic               rec_was_return_o,
   output logic               rec_was_indirect_o
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   generate
      if (RAS_DEPTH < 2 || (RAS_DEPTH & (RAS_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("RAS_DEPTH must be a power of two of at least 2");
      end
      if (PC_W < 8 || INST_BYTES < 1 || INST_BYTES > 16) begin : g_bad_pc
         $error("PC_W or INST_BYTES out of range");
      end
   endgenerate

   ctl_class_t cls;
   logic       dir;
   tgt_src_e   src;
   logic       sel_taken, sel_miss, sel_upd, sel_ind;
   logic       rc_push, rc_pop, rc_call;
   logic [IDX_W-1:0] rc_idx;
   logic [PC_W-1:0]  rc_tgt;
   logic [PC_W-1:0]  nxt;

   assign cls = '{uncond: is_uncond_i, call: is_call_i,
                  ret: is_ret_i, direct: is_direct_i};

   bts_dir_sel #(.IN_ORDER(IN_ORDER)) u_dir (
      .cls_i       (cls),
      .dir_taken_i (dir_taken_i),
      .ras_empty_i (ras_empty_i),
      .dir_o       (dir)
   );

   bts_tgt_sel #(.USE_INDIRECT(USE_INDIRECT), .IN_ORDER(IN_ORDER)) u_tgt (
      .cls_i     (cls),
      .dir_i     (dir),
      .btb_hit_i (btb_hit_i),
      .ind_hit_i (ind_hit_i),
      .src_o     (src),
      .taken_o   (sel_taken),
      .miss_o    (sel_miss),
      .dir_upd_o (sel_upd),
      .was_ind_o (sel_ind)
   );

   bts_ras_ctl #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ras (
      .cls_i      (cls),
      .dir_i      (dir),
      .miss_i     (sel_miss),
      .top_idx_i  (ras_top_idx_i),
      .top_tgt_i  (ras_top_tgt_i),
      .push_o     (rc_push),
      .pop_o      (rc_pop),
      .was_call_o (rc_call),
      .ck_idx_o   (rc_idx),
      .ck_tgt_o   (rc_tgt)
   );

   always_comb begin
      unique case (src)
         TS_RAS:  nxt = ras_top_tgt_i;
         TS_BTB:  nxt = btb_tgt_i;
         TS_IND:  nxt = ind_tgt_i;
         TS_IMM:  nxt = imm_tgt_i;
         default: nxt = pc_i + STEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o        <= 1'b0;
         taken_o            <= 1'b0;
         next_pc_o          <= '0;
         ras_push_o         <= 1'b0;
         ras_push_pc_o      <= '0;
         ras_pop_o          <= 1'b0;
         dir_btb_upd_o      <= 1'b0;
         rec_pc_o           <= '0;
         rec_used_ras_o     <= 1'b0;
         rec_ras_idx_o      <= '0;
         rec_ras_tgt_o      <= '0;
         rec_pushed_ras_o   <= 1'b0;
         rec_was_call_o     <= 1'b0;
         rec_was_return_o   <= 1'b0;
         rec_was_indirect_o <= 1'b0;
      end else begin
         out_valid_o   <= valid_i;
         ras_push_o    <= valid_i && rc_push;
         ras_pop_o     <= valid_i && rc_pop;
         dir_btb_upd_o <= valid_i && sel_upd;
         if (valid_i) begin
            taken_o            <= sel_taken;
            next_pc_o          <= nxt;
            ras_push_pc_o      <= pc_i;
            rec_pc_o           <= pc_i;
            rec_used_ras_o     <= rc_pop;
            rec_ras_idx_o      <= rc_idx;
            rec_ras_tgt_o      <= rc_tgt;
            rec_pushed_ras_o   <= rc_push;
            rec_was_call_o     <= rc_call;
            rec_was_return_o   <= is_ret_i;
            rec_was_indirect_o <= sel_ind;
         end
      end
   end

   // R13: the stack never sees both commands together
   p_push_pop_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(ras_push_o && ras_pop_o));

   // R6: a target-buffer training request only accompanies a not-taken result
   p_upd_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dir_btb_upd_o |-> !taken_o);

   // R6: every not-taken result continues sequentially
   p_seq_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !taken_o) |-> (next_pc_o == rec_pc_o + STEP));

   // R2: stack-sourced targets always retire the top entry
   p_used_pops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && rec_used_ras_o) |-> (ras_pop_o && taken_o));

   // R4: a surviving push belongs to a call and is really issued
   p_pushed_is_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && rec_pushed_ras_o) |-> (rec_was_call_o && ras_push_o));

   // R3: returns never push
   p_ret_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && rec_was_return_o) |-> !ras_push_o);

   // R12: commands are quiet when no result is presented
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> !(ras_push_o || ras_pop_o || dir_btb_upd_o));

endmodule

// File: tb/bts_ctrl_tb.sv
module bts_ctrl_tb;

   localparam int CLK_P = 10;
   localparam int NV    = 17;

   // [15] uncond [14] call [13] ret [12] direct
   // [11] dir [10] btb_hit [9] ind_hit [8] ras_empty
   // [7] exp taken [6:4] exp source (0 seq,1 stack,2 btb,3 ind,4 imm)
   // [3] exp push [2] exp pop [1] exp btb update [0] exp indirect flag
   localparam logic [15:0] VECS [NV] = '{
      16'b0001_1100_1_010_0000,
      16'b0001_0100_0_000_0000,
      16'b1001_0100_1_010_0000,
      16'b0001_1000_0_000_0010,
      16'b1001_0000_0_000_0010,
      16'b1010_0000_1_001_0100,
      16'b0010_0000_0_000_0000,
      16'b0010_1000_1_001_0100,
      16'b1101_0100_1_010_1000,
      16'b1101_0000_0_000_1000,
      16'b0101_1000_0_000_0000,
      16'b0101_1100_1_010_1000,
      16'b1000_0010_1_011_0001,
      16'b1000_0100_0_000_0001,
      16'b0100_1000_0_000_0001,
      16'b1100_0010_1_011_1001,
      16'b1010_0001_1_001_0100
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic valid_i = 1'b0;
   logic is_uncond_i = 1'b0, is_call_i = 1'b0, is_ret_i = 1'b0, is_direct_i = 1'b0;
   logic [31:0] pc_i = '0, btb_tgt_i = '0, ind_tgt_i = '0, ras_top_tgt_i = '0, imm_tgt_i = '0;
   logic dir_taken_i = 1'b0, btb_hit_i = 1'b0, ind_hit_i = 1'b0, ras_empty_i = 1'b0;
   logic [3:0] ras_top_idx_i = '0;

   logic        ov [3];
   logic        tk [3];
   logic [31:0] np [3];
   logic        pu [3];
   logic [31:0] pp [3];
   logic        po [3];
   logic        up [3];
   logic [31:0] rpc [3];
   logic        rur [3];
   logic [3:0]  rix [3];
   logic [31:0] rtg [3];
   logic        rps [3];
   logic        rwc [3];
   logic        rwr [3];
   logic        rwi [3];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bts_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
      .is_uncond_i(is_uncond_i), .is_call_i(is_call_i), .is_ret_i(is_ret_i),
      .is_direct_i(is_direct_i), .pc_i(pc_i), .dir_taken_i(dir_taken_i),
      .btb_hit_i(btb_hit_i), .btb_tgt_i(btb_tgt_i), .ind_hit_i(ind_hit_i),
      .ind_tgt_i(ind_tgt_i), .ras_top_tgt_i(ras_top_tgt_i),
      .ras_top_idx_i(ras_top_idx_i), .ras_empty_i(ras_empty_i), .imm_tgt_i(imm_tgt_i),
      .out_valid_o(ov[0]), .taken_o(tk[0]), .next_pc_o(np[0]), .ras_push_o(pu[0]),
      .ras_push_pc_o(pp[0]), .ras_pop_o(po[0]), .dir_btb_upd_o(up[0]),
      .rec_pc_o(rpc[0]), .rec_used_ras_o(rur[0]), .rec_ras_idx_o(rix[0]),
      .rec_ras_tgt_o(rtg[0]), .rec_pushed_ras_o(rps[0]), .rec_was_call_o(rwc[0]),
      .rec_was_return_o(rwr[0]), .rec_was_indirect_o(rwi[0])
   );

   bts_ctrl #(.USE_INDIRECT(1'b0)) u_dut_noind (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
      .is_uncond_i(is_uncond_i), .is_call_i(is_call_i), .is_ret_i(is_ret_i),
      .is_direct_i(is_direct_i), .pc_i(pc_i), .dir_taken_i(dir_taken_i),
      .btb_hit_i(btb_hit_i), .btb_tgt_i(btb_tgt_i), .ind_hit_i(ind_hit_i),
      .ind_tgt_i(ind_tgt_i), .ras_top_tgt_i(ras_top_tgt_i),
      .ras_top_idx_i(ras_top_idx_i), .ras_empty_i(ras_empty_i), .imm_tgt_i(imm_tgt_i),
      .out_valid_o(ov[1]), .taken_o(tk[1]), .next_pc_o(np[1]), .ras_push_o(pu[1]),
      .ras_push_pc_o(pp[1]), .ras_pop_o(po[1]), .dir_btb_upd_o(up[1]),
      .rec_pc_o(rpc[1]), .rec_used_ras_o(rur[1]), .rec_ras_idx_o(rix[1]),
      .rec_ras_tgt_o(rtg[1]), .rec_pushed_ras_o(rps[1]), .rec_was_call_o(rwc[1]),
      .rec_was_return_o(rwr[1]), .rec_was_indirect_o(rwi[1])
   );

   bts_ctrl #(.USE_INDIRECT(1'b0), .IN_ORDER(1'b1)) u_dut_inord (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
      .is_uncond_i(is_uncond_i), .is_call_i(is_call_i), .is_ret_i(is_ret_i),
      .is_direct_i(is_direct_i), .pc_i(pc_i), .dir_taken_i(dir_taken_i),
      .btb_hit_i(btb_hit_i), .btb_tgt_i(btb_tgt_i), .ind_hit_i(ind_hit_i),
      .ind_tgt_i(ind_tgt_i), .ras_top_tgt_i(ras_top_tgt_i),
      .ras_top_idx_i(ras_top_idx_i), .ras_empty_i(ras_empty_i), .imm_tgt_i(imm_tgt_i),
      .out_valid_o(ov[2]), .taken_o(tk[2]), .next_pc_o(np[2]), .ras_push_o(pu[2]),
      .ras_push_pc_o(pp[2]), .ras_pop_o(po[2]), .dir_btb_upd_o(up[2]),
      .rec_pc_o(rpc[2]), .rec_used_ras_o(rur[2]), .rec_ras_idx_o(rix[2]),
      .rec_ras_tgt_o(rtg[2]), .rec_pushed_ras_o(rps[2]), .rec_was_call_o(rwc[2]),
      .rec_was_return_o(rwr[2]), .rec_was_indirect_o(rwi[2])
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // present one instruction at a falling edge and return after the next falling edge
   task automatic issue(input logic [7:0] ctl, input int tag);
      @(negedge clk);
      {is_uncond_i, is_call_i, is_ret_i, is_direct_i} = ctl[7:4];
      {dir_taken_i, btb_hit_i, ind_hit_i, ras_empty_i} = ctl[3:0];
      pc_i          = 32'h0000_1000 + 32'(tag) * 16;
      btb_tgt_i     = 32'hB000_0000 + 32'(tag) * 256;
      ind_tgt_i     = 32'hC000_0000 + 32'(tag) * 256;
      ras_top_tgt_i = 32'hD000_0000 + 32'(tag) * 256;
      imm_tgt_i     = 32'hE000_0000 + 32'(tag) * 256;
      ras_top_idx_i = 4'(tag);
      valid_i       = 1'b1;
      @(negedge clk);
      valid_i       = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R12: reset state
      #(CLK_P * 2 + 1);
      chk("R12 reset out_valid", 32'(ov[0]), 32'd0);
      chk("R12 reset push", 32'(pu[0]), 32'd0);
      chk("R12 reset pop", 32'(po[0]), 32'd0);
      chk("R12 reset next_pc", np[0], 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         logic [31:0] exp_pc;
         logic        e_dir;
         v = VECS[i];
         issue(v[15:8], i);
         case (v[6:4])
            3'd1:    exp_pc = 32'hD000_0000 + 32'(i) * 256;
            3'd2:    exp_pc = 32'hB000_0000 + 32'(i) * 256;
            3'd3:    exp_pc = 32'hC000_0000 + 32'(i) * 256;
            3'd4:    exp_pc = 32'hE000_0000 + 32'(i) * 256;
            default: exp_pc = 32'h0000_1004 + 32'(i) * 16;
         endcase
         e_dir = v[15] | v[11];
         chk($sformatf("R12 row%0d out_valid", i), 32'(ov[0]), 32'd1);
         chk($sformatf("R1 row%0d taken", i), 32'(tk[0]), 32'(v[7]));
         chk($sformatf("R5 row%0d next_pc", i), np[0], exp_pc);
         chk($sformatf("R4 row%0d push", i), 32'(pu[0]), 32'(v[3]));
         chk($sformatf("R2 row%0d pop", i), 32'(po[0]), 32'(v[2]));
         chk($sformatf("R2 row%0d used_ras", i), 32'(rur[0]), 32'(v[2]));
         chk($sformatf("R6 row%0d btb update", i), 32'(up[0]), 32'(v[1]));
         chk($sformatf("R8 row%0d was_indirect", i), 32'(rwi[0]), 32'(v[0]));
         chk($sformatf("R7 row%0d pushed_ras", i), 32'(rps[0]), 32'(v[3]));
         chk($sformatf("R7 row%0d was_call", i), 32'(rwc[0]),
             32'(e_dir & v[14] & ~v[13]));
         chk($sformatf("R3 row%0d was_return", i), 32'(rwr[0]), 32'(v[13]));
         chk($sformatf("R3 row%0d ckpt tgt", i), rtg[0],
             v[13] ? 32'hD000_0000 + 32'(i) * 256 : 32'd0);
         chk($sformatf("R3 row%0d ckpt idx", i), 32'(rix[0]), v[13] ? 32'(i % 16) : 32'd0);
         if (v[3]) chk($sformatf("R4 row%0d push pc", i), pp[0], 32'h0000_1000 + 32'(i) * 16);
         chk($sformatf("R13 row%0d push&pop", i), 32'(pu[0] & po[0]), 32'd0);
         chk($sformatf("R10 row%0d record pc", i), rpc[0], 32'h0000_1000 + 32'(i) * 16);
      end

      // R12: idle cycle after the last instruction
      @(negedge clk);
      chk("R12 idle out_valid", 32'(ov[0]), 32'd0);
      chk("R12 idle commands", 32'({pu[0], po[0], up[0]}), 32'd0);

      // R9: indirect branch through the target buffer when indirect prediction is off
      issue(8'b1000_0100, 40);
      chk("R9 noind taken", 32'(tk[1]), 32'd1);
      chk("R9 noind next_pc", np[1], 32'hB000_0000 + 40 * 256);
      chk("R9 noind was_indirect", 32'(rwi[1]), 32'd0);
      chk("R8 ind-on miss ignores btb", np[0], 32'h0000_1004 + 40 * 16);
      issue(8'b1000_0010, 41);
      chk("R9 noind miss taken", 32'(tk[1]), 32'd0);
      chk("R9 noind miss update", 32'(up[1]), 32'd1);
      chk("R9 noind miss next_pc", np[1], 32'h0000_1004 + 41 * 16);

      // R10: in-order guard on unconditional returns
      issue(8'b1010_0001, 42);
      chk("R10 inord empty taken", 32'(tk[2]), 32'd0);
      chk("R10 inord empty pop", 32'(po[2]), 32'd0);
      chk("R10 inord empty next_pc", np[2], 32'h0000_1004 + 42 * 16);
      chk("R10 ooo empty ignored", np[0], 32'hD000_0000 + 42 * 256);
      issue(8'b1010_0000, 43);
      chk("R10 inord nonempty taken", 32'(tk[2]), 32'd1);
      chk("R10 inord nonempty next_pc", np[2], 32'hD000_0000 + 43 * 256);

      // R11: in-order immediate target on unconditional direct calls
      issue(8'b1101_0000, 44);
      chk("R11 inord call taken", 32'(tk[2]), 32'd1);
      chk("R11 inord call next_pc", np[2], 32'hE000_0000 + 44 * 256);
      chk("R11 inord call push", 32'(pu[2]), 32'd1);
      chk("R11 ooo call misses", 32'(tk[0]), 32'd0);
      issue(8'b1101_0100, 45);
      chk("R11 inord call ignores btb", np[2], 32'hE000_0000 + 45 * 256);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule